// File: doc/BRIEF.md
# Clause 45 MDIO Management Controller

This block lets software run Clause 45 management frames toward external PHYs through four 32-bit memory-mapped registers. Software sets the port and device address in the control register. A write to the address register sends an address frame. After that, a write to the data register sends a write frame, or a control write with the read request bit set sends a read frame. When a read completes, the value captured from the PHY appears in the data register.

The controller generates the management clock from a programmable divider. It drives the serial line through an output and an output-enable pin, and samples it through a separate input. Address frames and read/write frames are tracked by two separate busy flags: one in the status register and one in the data register. If a PHY stays silent during the read turnaround, the controller flags a read error and returns all ones.

Top module: `mgmtBusCtrl`

## Requirements
- R1: After reset every register reads zero, the management clock is low and the line is not driven.
- R2: Registers are decoded at byte offsets 0x30 (status), 0x34 (control), 0x38 (data) and 0x3C (address). Status bits 15:8 are a writable divider field. Status bit 0 (address busy) and bit 1 (read error) cannot be written. Control bits 4:0 (device), 9:5 (port), 10 (no preamble), 11 (scan), 14 (post-increment) and 15 (read) read back as written. Every other offset reads zero and ignores writes.
- R3: Writing the address register sends a frame with opcode 00, turnaround 10 and the written 16 bits. Status bit 0 is 1 from the cycle after the write until the frame ends, and data bit 31 stays 0.
- R4: Writing the data register sends a frame with opcode 01, turnaround 10 and the written 16 bits. Data bit 31 is 1 for the whole frame, and status bit 0 stays 0.
- R5: A control write with bit 15 set sends a frame with opcode 11. The controller releases the line from the first turnaround bit to the end of the frame and shifts in 16 bits MSB first. Once the frame ends they read back in data bits 15:0.
- R6: If bit 14 is also set in that control write, the read frame carries opcode 10 instead.
- R7: Each frame is sent MSB first: 32 ones of preamble, then start 00, the 2-bit opcode, the 5-bit port, the 5-bit device, 2 turnaround bits and 16 payload bits. Control bit 10 removes the preamble, leaving 32 bits.
- R8: The management clock idles low and has a period of 2*(divider+1) system clocks. The line changes only when the clock falls.
- R9: If the line reads 1 in the second turnaround bit of a read, status bit 1 is set and the data register reads 0xFFFF. The flag clears as soon as the next frame starts.
- R10: While either busy flag is set, register writes are dropped: no register changes and no further frame starts.
- R11: The scan bit is only stored; setting it sends no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven onto the management line |
| mdioOe | output | 1 | Output enable for the management line |
| mdioIn | input | 1 | Sampled level of the management line |

## Verification
The hardest cases to reach are the read turnaround and the silent PHY, because they depend on the external device answering in the right bit. The bench includes a PHY model that counts management clock edges. After a falling edge it either pulls the line low in the second turnaround bit and presents its data, or leaves the line at its pulled-up level. The bench records the line and the enable at every rising edge, so it can compare both the transmitted bits and the point of release against expected values. To check that writes are dropped while a frame is running, the bench issues address, data and read-start writes in the middle of an address frame and then inspects the registers and the recorded bit count.

// File: rtl/mgmtPkg.sv
package mgmtPkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int DIV_W      = 8;
  localparam int SR_W       = PRE_BITS + FRAME_BITS;

  localparam logic [1:0] OP_ADDR     = 2'b00;
  localparam logic [1:0] OP_WRITE    = 2'b01;
  localparam logic [1:0] OP_READ     = 2'b11;
  localparam logic [1:0] OP_READ_INC = 2'b10;

  typedef struct packed {
    logic load;
    logic shift;
    logic sampleTa;
    logic sampleData;
    logic done;
  } mgmtStrobeT;
endpackage

// File: rtl/mgmtSeq.sv
module mgmtSeq
  import mgmtPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startAddr,
  input  logic             startWr,
  input  logic             startRd,
  input  logic             preDisNext,
  input  logic [DIV_W-1:0] halfDiv,
  output mgmtStrobeT       stb,
  output logic             mdc,
  output logic             addrBusy,
  output logic             dataBusy,
  output logic             readFrame,
  output logic             mdioOe
);
  localparam int REM_W = $clog2(SR_W + 1);
  localparam logic [REM_W-1:0] REM_FULL  = REM_W'(SR_W);
  localparam logic [REM_W-1:0] REM_SHORT = REM_W'(FRAME_BITS);
  localparam logic [REM_W-1:0] REM_TA1   = REM_W'(FRAME_BITS - 14);
  localparam logic [REM_W-1:0] REM_TA2   = REM_W'(FRAME_BITS - 15);
  localparam logic [REM_W-1:0] REM_DATA  = REM_W'(16);

  logic [DIV_W-1:0] divCnt;
  logic [REM_W-1:0] remBits;
  logic busy, startAny, edgeTick, riseTick, fallTick, lastBit;

  assign busy     = addrBusy | dataBusy;
  assign startAny = !busy && (startAddr || startWr || startRd);
  assign edgeTick = busy && (divCnt == halfDiv);
  assign riseTick = edgeTick && !mdc;
  assign fallTick = edgeTick && mdc;
  assign lastBit  = (remBits == REM_W'(1));

  always_comb begin
    stb.load       = startAny;
    stb.shift      = fallTick && !lastBit;
    stb.done       = fallTick && lastBit;
    stb.sampleTa   = riseTick && readFrame && (remBits == REM_TA2);
    stb.sampleData = riseTick && readFrame && (remBits <= REM_DATA);
  end

  assign mdioOe = busy && !(readFrame && (remBits <= REM_TA1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrBusy  <= 1'b0;
      dataBusy  <= 1'b0;
      readFrame <= 1'b0;
      remBits   <= '0;
      divCnt    <= '0;
      mdc       <= 1'b0;
    end else if (startAny) begin
      addrBusy  <= startAddr;
      dataBusy  <= startWr | startRd;
      readFrame <= startRd;
      remBits   <= preDisNext ? REM_SHORT : REM_FULL;
      divCnt    <= '0;
      mdc       <= 1'b0;
    end else if (busy) begin
      if (edgeTick) begin
        divCnt <= '0;
        mdc    <= ~mdc;
        if (mdc) begin
          if (lastBit) begin
            addrBusy  <= 1'b0;
            dataBusy  <= 1'b0;
            readFrame <= 1'b0;
          end else begin
            remBits <= remBits - REM_W'(1);
          end
        end
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(addrBusy && dataBusy)); // R10
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !(addrBusy || dataBusy) |-> !mdc); // R8
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (addrBusy || dataBusy) |-> (divCnt <= halfDiv)); // R8
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.done) |=> $stable(readFrame)); // R10
endmodule

// File: rtl/mgmtRegs.sv
module mgmtRegs
  import mgmtPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_BASE = 'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  mgmtStrobeT        stb,
  input  logic              addrBusy,
  input  logic              dataBusy,
  input  logic              readFrame,
  input  logic              mdioIn,
  output logic              startAddr,
  output logic              startWr,
  output logic              startRd,
  output logic              preDisNext,
  output logic [DIV_W-1:0]  halfDiv,
  output logic              mdioOut
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] W_STAT = WA_W'(REG_BASE / 4);
  localparam logic [WA_W-1:0] W_CTL  = WA_W'(REG_BASE / 4 + 1);
  localparam logic [WA_W-1:0] W_DATA = WA_W'(REG_BASE / 4 + 2);
  localparam logic [WA_W-1:0] W_ADDR = WA_W'(REG_BASE / 4 + 3);

  logic [4:0]  devAddr, portAddr, nextDev, nextPort;
  logic        preDis, scanEn, postInc, rdReq, nextPostInc;
  logic [15:0] dataReg, addrReg, capture, payload;
  logic        readErr;
  logic [SR_W-1:0] sr;
  logic [1:0]  opcode, taBits;
  logic [FRAME_BITS-1:0] frame;
  logic [WA_W-1:0] word;
  logic wrOk, wrStat, wrCtl, wrData, wrAddr;
  logic unusedBits;

  assign unusedBits = ^{busWrData[31:16], busWrData[13:12], busAddr[1:0]};

  assign word   = busAddr[ADDR_W-1:2];
  assign wrOk   = busWrEn && !(addrBusy || dataBusy);
  assign wrStat = wrOk && (word == W_STAT);
  assign wrCtl  = wrOk && (word == W_CTL);
  assign wrData = wrOk && (word == W_DATA);
  assign wrAddr = wrOk && (word == W_ADDR);

  assign startAddr = wrAddr;
  assign startWr   = wrData;
  assign startRd   = wrCtl && busWrData[15];

  assign nextDev     = wrCtl ? busWrData[4:0]  : devAddr;
  assign nextPort    = wrCtl ? busWrData[9:5]  : portAddr;
  assign preDisNext  = wrCtl ? busWrData[10]   : preDis;
  assign nextPostInc = wrCtl ? busWrData[14]   : postInc;

  always_comb begin
    if (startAddr) begin
      opcode  = OP_ADDR;
      taBits  = 2'b10;
      payload = busWrData[15:0];
    end else if (startWr) begin
      opcode  = OP_WRITE;
      taBits  = 2'b10;
      payload = busWrData[15:0];
    end else begin
      opcode  = nextPostInc ? OP_READ_INC : OP_READ;
      taBits  = 2'b11;
      payload = 16'hFFFF;
    end
    frame = {2'b00, opcode, nextPort, nextDev, taBits, payload};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfDiv  <= '0;
      devAddr  <= '0;
      portAddr <= '0;
      preDis   <= 1'b0;
      scanEn   <= 1'b0;
      postInc  <= 1'b0;
      rdReq    <= 1'b0;
      addrReg  <= '0;
    end else begin
      if (wrStat) halfDiv <= busWrData[15:8];
      if (wrCtl) begin
        devAddr  <= busWrData[4:0];
        portAddr <= busWrData[9:5];
        preDis   <= busWrData[10];
        scanEn   <= busWrData[11];
        postInc  <= busWrData[14];
        rdReq    <= busWrData[15];
      end
      if (wrAddr) addrReg <= busWrData[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sr      <= '0;
      capture <= '0;
      readErr <= 1'b0;
      dataReg <= '0;
    end else begin
      if (stb.load)
        sr <= preDisNext ? {frame, {PRE_BITS{1'b0}}} : {{PRE_BITS{1'b1}}, frame};
      else if (stb.shift)
        sr <= {sr[SR_W-2:0], 1'b0};
      if (stb.sampleData) capture <= {capture[14:0], mdioIn};
      if (stb.load) readErr <= 1'b0;
      else if (stb.sampleTa && mdioIn) readErr <= 1'b1;
      if (wrData) dataReg <= busWrData[15:0];
      else if (stb.done && readFrame) dataReg <= readErr ? 16'hFFFF : capture;
    end
  end

  assign mdioOut = sr[SR_W-1];

  always_comb begin
    case (word)
      W_STAT:  busRdData = {16'h0, halfDiv, 6'h0, readErr, addrBusy};
      W_CTL:   busRdData = {16'h0, rdReq, postInc, 2'b00, scanEn, preDis, portAddr, devAddr};
      W_DATA:  busRdData = {dataBusy, 15'h0, dataReg};
      W_ADDR:  busRdData = {16'h0, addrReg};
      default: busRdData = 32'h0;
    endcase
  end

  AST_ERR_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !readErr); // R9
  AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.done && readFrame && readErr) |=> (dataReg == 16'hFFFF)); // R9
  AST_BUSY_DROPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ((addrBusy || dataBusy) && !stb.done) |=> $stable(dataReg)); // R10
  AST_BUSY_DROPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (addrBusy || dataBusy) |=> $stable(addrReg)); // R10
endmodule

// File: rtl/mgmtBusCtrl.sv
module mgmtBusCtrl
  import mgmtPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_BASE = 'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mgmtStrobeT stb;
  logic startAddr, startWr, startRd, preDisNext;
  logic addrBusy, dataBusy, readFrame;
  logic [DIV_W-1:0] halfDiv;

  mgmtRegs #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) i_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .stb(stb),
    .addrBusy(addrBusy), .dataBusy(dataBusy), .readFrame(readFrame),
    .mdioIn(mdioIn), .startAddr(startAddr), .startWr(startWr),
    .startRd(startRd), .preDisNext(preDisNext), .halfDiv(halfDiv),
    .mdioOut(mdioOut)
  );

  mgmtSeq i_seq (
    .clk(clk), .rstN(rstN), .startAddr(startAddr), .startWr(startWr),
    .startRd(startRd), .preDisNext(preDisNext), .halfDiv(halfDiv),
    .stb(stb), .mdc(mdc), .addrBusy(addrBusy), .dataBusy(dataBusy),
    .readFrame(readFrame), .mdioOe(mdioOe)
  );

  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut)); // R8
  AST_OE_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOe)); // R5
endmodule

// File: tb/test_mgmtBusCtrl.sv
`timescale 1ns/1ps
module test_mgmtBusCtrl;
  localparam logic [7:0] A_STAT = 8'h30, A_CTL = 8'h34, A_DATA = 8'h38, A_ADDR = 8'h3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = 8'h0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic mdc, mdioOut, mdioOe, mdioIn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic phyDrv = 1'b1;
  logic phyAnswer = 1'b0;
  logic [15:0] phyData = 16'h0;
  int preOff = 32;
  int frameBase = 0;
  int capCnt = 0;
  int phyIdx;
  logic [63:0] capBits = '0;
  logic [63:0] oeBits = '0;
  time lastRise = 0;
  time risePeriod = 0;

  always #5 clk = ~clk;

  assign mdioIn = mdioOe ? mdioOut : phyDrv;

  mgmtBusCtrl i_mgmtBusCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc) begin
    capBits = {capBits[62:0], mdioIn};
    oeBits  = {oeBits[62:0], mdioOe};
    capCnt  = capCnt + 1;
    risePeriod = $time - lastRise;
    lastRise = $time;
  end

  always @(negedge mdc) begin
    phyIdx = capCnt - frameBase - preOff;
    if (phyAnswer && phyIdx == 15) phyDrv = 1'b0;
    else if (phyAnswer && phyIdx >= 16 && phyIdx <= 31) phyDrv = phyData[31 - phyIdx];
    else phyDrv = 1'b1;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s, d;
    for (int i = 0; i < 20000; i++) begin
      busRead(A_STAT, s);
      busRead(A_DATA, d);
      if (!s[0] && !d[31]) return;
    end
    check("waitIdle timeout", 1, 0);
  endtask

  function automatic logic [31:0] frameOf(input logic [1:0] op, input logic [4:0] port,
                                          input logic [4:0] dev, input logic [1:0] ta,
                                          input logic [15:0] pay);
    return {2'b00, op, port, dev, ta, pay};
  endfunction

  task automatic testReset();
    logic [31:0] v;
    busRead(A_STAT, v); check("R1 status after reset", v, 0);
    busRead(A_CTL, v);  check("R1 control after reset", v, 0);
    busRead(A_DATA, v); check("R1 data after reset", v, 0);
    busRead(A_ADDR, v); check("R1 address after reset", v, 0);
    check("R1 mdc idle low", mdc, 0);
    check("R1 line released", mdioOe, 0);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    busWrite(A_STAT, 32'h0000_0303);
    busRead(A_STAT, v); check("R2 divider field, flags read-only", v, 32'h0000_0300);
    frameBase = capCnt;
    busWrite(A_CTL, 32'h0000_0BA5);
    busRead(A_CTL, v); check("R2 control fields readback", v, 32'h0000_0BA5);
    repeat (100) @(negedge clk);
    check("R11 scan bit starts no frame", capCnt - frameBase, 0);
    busWrite(8'h00, 32'hFFFF_FFFF);
    busRead(8'h00, v); check("R2 reserved word reads zero", v, 0);
    busRead(A_STAT, v); check("R2 reserved write leaves status", v, 32'h0000_0300);
  endtask

  task automatic testAddrFrame();
    logic [31:0] v;
    busWrite(A_STAT, 32'h0000_0400);
    busWrite(A_CTL, 32'h0000_0061);
    preOff = 32; phyAnswer = 1'b0; frameBase = capCnt;
    busWrite(A_ADDR, 32'h0000_1234);
    busRead(A_STAT, v); check("R3 address busy set", v, 32'h0000_0401);
    busRead(A_DATA, v); check("R3 data busy stays low", v[31], 0);
    waitIdle();
    check("R7 preamble frame length", capCnt - frameBase, 64);
    check("R3 R7 address frame bits", capBits,
          {32'hFFFF_FFFF, frameOf(2'b00, 5'd3, 5'd1, 2'b10, 16'h1234)});
    check("R8 mdc period divider 4", risePeriod, 100);
    busRead(A_STAT, v); check("R3 address busy cleared", v, 32'h0000_0400);
    busRead(A_ADDR, v); check("R3 address readback", v, 32'h0000_1234);
    check("R8 mdc low after frame", mdc, 0);
  endtask

  task automatic testWriteFrame();
    logic [31:0] v;
    busWrite(A_STAT, 32'h0000_0100);
    busWrite(A_CTL, 32'h0000_063E);
    preOff = 0; frameBase = capCnt;
    busWrite(A_DATA, 32'h0000_BEEF);
    busRead(A_DATA, v); check("R4 data busy set", v, 32'h8000_BEEF);
    busRead(A_STAT, v); check("R4 address busy stays low", v[0], 0);
    waitIdle();
    check("R7 no preamble frame length", capCnt - frameBase, 32);
    check("R4 write frame bits", capBits[31:0], frameOf(2'b01, 5'h11, 5'h1E, 2'b10, 16'hBEEF));
    check("R8 mdc period divider 1", risePeriod, 40);
    busRead(A_DATA, v); check("R4 data after write", v, 32'h0000_BEEF);
  endtask

  task automatic testRead();
    logic [31:0] v;
    preOff = 32; phyAnswer = 1'b1; phyData = 16'hA5C3; frameBase = capCnt;
    busWrite(A_CTL, 32'h0000_8047);
    busRead(A_DATA, v); check("R5 data busy during read", v[31], 1);
    waitIdle();
    check("R5 read frame length", capCnt - frameBase, 64);
    check("R5 read frame line", capBits[31:0], frameOf(2'b11, 5'd2, 5'd7, 2'b10, 16'hA5C3));
    check("R5 release from turnaround", oeBits[31:0], 32'hFFFC_0000);
    busRead(A_DATA, v); check("R5 captured data", v, 32'h0000_A5C3);
    busRead(A_STAT, v); check("R5 no read error", v, 32'h0000_0100);
  endtask

  task automatic testPostInc();
    logic [31:0] v;
    preOff = 0; phyAnswer = 1'b1; phyData = 16'h0F0F; frameBase = capCnt;
    busWrite(A_CTL, 32'h0000_C482);
    waitIdle();
    check("R6 R7 post-increment frame length", capCnt - frameBase, 32);
    check("R6 post-increment opcode", capBits[31:0], frameOf(2'b10, 5'd4, 5'd2, 2'b10, 16'h0F0F));
    busRead(A_DATA, v); check("R6 post-increment data", v, 32'h0000_0F0F);
  endtask

  task automatic testReadErr();
    logic [31:0] v;
    preOff = 0; phyAnswer = 1'b0; frameBase = capCnt;
    busWrite(A_CTL, 32'h0000_84A9);
    waitIdle();
    busRead(A_STAT, v); check("R9 read error set", v, 32'h0000_0102);
    busRead(A_DATA, v); check("R9 data all ones", v, 32'h0000_FFFF);
    busWrite(A_ADDR, 32'h0000_0042);
    busRead(A_STAT, v); check("R9 error cleared at next start", v, 32'h0000_0101);
    waitIdle();
    busRead(A_STAT, v); check("R9 status after address frame", v, 32'h0000_0100);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] v;
    preOff = 0; phyAnswer = 1'b0; frameBase = capCnt;
    busWrite(A_ADDR, 32'h0000_5555);
    repeat (5) @(negedge clk);
    busWrite(A_DATA, 32'h0000_1111);
    busWrite(A_ADDR, 32'h0000_2222);
    busWrite(A_CTL, 32'h0000_8000);
    busWrite(A_STAT, 32'h0000_0700);
    waitIdle();
    repeat (100) @(negedge clk);
    check("R10 only one frame sent", capCnt - frameBase, 32);
    busRead(A_ADDR, v); check("R10 address kept", v, 32'h0000_5555);
    busRead(A_DATA, v); check("R10 data kept", v, 32'h0000_FFFF);
    busRead(A_CTL, v);  check("R10 control kept", v, 32'h0000_84A9);
    busRead(A_STAT, v); check("R10 divider kept", v, 32'h0000_0100);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testAddrFrame();
    testWriteFrame();
    testRead();
    testPostInc();
    testReadErr();
    testBusyIgnore();
    summary();
    $finish;
  end
endmodule